// File: doc/BRIEF.md
# Trap Entry Sequencer

This block decides, cycle by cycle, whether a small 32-bit soft processor enters a trap handler, and if so which one. It watches four request lines: an external interrupt, a hardware exception, a memory-management fault (with cause code, store flag and faulting address) and a hardware break. It also sees the current program counter, the pending branch target, the delay-slot, immediate-prefix and branch-had-prefix flags, and the present machine-status and exception-status words. The block owns no architectural registers. In the cycle a trap is taken it presents the new PC, one register-file write carrying the return address, and the next values of the machine-status, exception-status, exception-address and branch-target registers, each with its own write enable. The surrounding pipeline latches these values at the next rising edge.

Every entry saves the live translation and user-mode bits into shadow bits one position higher, then clears the live bits, so the handler runs privileged with translation off. A three-state machine guards against recursive memory-management faults. **ST_RUN** is the normal state. On a memory-management entry it moves to **ST_MMU_PEND**, and it stays there while the exception-in-progress bit of the incoming status word is set. It returns to **ST_RUN** once that bit reads clear. A second memory-management fault seen in **ST_MMU_PEND** moves it to **ST_HALT**, where no trap is ever taken and the fatal flag is raised until reset.

Top module: `trap_entry_ctrl`

## Requirements
- R1: An interrupt is taken only when status bit 1 (interrupt enable) is set, status bits 9 (exception in progress) and 3 (break in progress) are clear, and neither `in_dslot` nor `after_imm` is set. Otherwise it produces no entry.
- R2: Simultaneous requests resolve as break, then memory fault, then hardware exception, then interrupt. At most one entry is taken per cycle. `entry_taken` is high only in that cycle, and `entry_kind` reports 0 none, 1 interrupt, 2 hardware exception, 3 memory fault, 4 break. With no entry, every write enable is low.
- R3: `new_pc` is VEC_BASE+0x10 for an interrupt, VEC_BASE+0x18 for a break, and VEC_BASE+0x20 for either exception.
- R4: On every entry, the next status word copies bit 13 (translation) into bit 14 and bit 11 (user mode) into bit 12, then clears bits 13 and 11. All other bits are kept unless R8 sets them.
- R5: The return write goes to register 14 with the PC for an interrupt, to register 17 with PC+4 for a hardware exception, to register 17 for a memory fault, and to register 16 with the PC for a break.
- R6: The return address of a memory fault is PC-4 in a delay slot, or PC-8 there if the branch had an immediate prefix. It is PC-4 right after an immediate prefix, and the PC otherwise.
- R7: On either exception, exception-status bit 12 takes the delay-slot flag. When the flag is set, the branch-target register is written with `cur_btarget`. Otherwise it is not written.
- R8: Either exception entry sets status bit 9, and a break entry sets status bit 3.
- R9: A memory fault writes the fault address to the exception-address register and writes exception status 16 + `mmu_cause` (0 data protection, 1 instruction protection, 2 data miss, 3 instruction miss), with bit 10 set for a store. A hardware exception keeps the incoming status apart from bit 12. Interrupts and breaks leave both registers unwritten.
- R10: `flags_clr` is high exactly on exception entries.
- R11: After a memory-fault entry, a further memory-fault request taken before status bit 9 reads clear takes no entry, and `fatal_err` rises the next cycle and blocks all entries until reset. Other requests are still taken while pending, and pending ends in a cycle where bit 9 reads clear.
- R12: While `rst_n` is low no entry is taken, and after reset `fatal_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | External interrupt request |
| hwexc_req | input | 1 | Hardware exception request |
| mmu_req | input | 1 | Memory-management fault request |
| mmu_cause | input | 2 | Fault cause code |
| mmu_store | input | 1 | Faulting access was a store |
| mmu_addr | input | 32 | Faulting address |
| brk_req | input | 1 | Hardware break request |
| cur_pc | input | 32 | PC of the current instruction |
| cur_btarget | input | 32 | Pending branch target |
| in_dslot | input | 1 | Current instruction sits in a delay slot |
| after_imm | input | 1 | Current instruction follows an immediate prefix |
| branch_had_imm | input | 1 | The branch owning the delay slot had a prefix |
| cur_msr | input | 32 | Present machine-status word |
| cur_esr | input | 32 | Present exception-status word |
| entry_taken | output | 1 | A trap is entered this cycle |
| entry_kind | output | 3 | Kind of trap entered |
| new_pc | output | 32 | Handler vector |
| rf_we | output | 1 | Return-address write enable |
| rf_idx | output | 5 | Return register index |
| rf_data | output | 32 | Return address |
| msr_we | output | 1 | Status write enable |
| msr_next | output | 32 | Next machine-status word |
| esr_we | output | 1 | Exception-status write enable |
| esr_next | output | 32 | Next exception-status word |
| ear_we | output | 1 | Exception-address write enable |
| ear_next | output | 32 | Next exception address |
| btr_we | output | 1 | Branch-target write enable |
| btr_next | output | 32 | Next branch-target value |
| flags_clr | output | 1 | Clear delay-slot and prefix flags |
| fatal_err | output | 1 | Recursive memory fault seen |

## Verification
The entry decision, vector, return write and every register value are combinational from the inputs and the state, so they are due in the same cycle the request is driven. The bench drives each stimulus just after a rising edge and compares at the following falling edge. The state machine's effects show up one edge later: the move into or out of the pending state, and the fatal flag after a recursive fault. The directed sequence therefore checks them on the next driven cycle. Each table row is followed by an idle cycle with a clear status word, so every row starts from ST_RUN.

// File: rtl/trap_pkg.sv
package trap_pkg;

    // machine-status bit positions
    localparam int MSR_IE     = 1;
    localparam int MSR_BIP    = 3;
    localparam int MSR_EIP    = 9;
    localparam int MSR_UM     = 11;
    localparam int MSR_VM     = 13;
    localparam int SHADOW_OFS = 1;

    // exception-status bit positions and fault code base
    localparam int ESR_ST_BIT   = 10;
    localparam int ESR_DS_BIT   = 12;
    localparam int ESR_MMU_BASE = 16;

    // handler vector offsets from the base
    localparam int VOFS_IRQ = 'h10;
    localparam int VOFS_BRK = 'h18;
    localparam int VOFS_EXC = 'h20;

    // return-address register numbers
    localparam int RET_IRQ = 14;
    localparam int RET_BRK = 16;
    localparam int RET_EXC = 17;

    // request slots, highest priority first
    localparam int NREQ     = 4;
    localparam int SLOT_BRK = 0;
    localparam int SLOT_MMU = 1;
    localparam int SLOT_HWX = 2;
    localparam int SLOT_IRQ = 3;

    typedef enum logic [2:0] {
        TK_NONE  = 3'd0,
        TK_IRQ   = 3'd1,
        TK_HWEXC = 3'd2,
        TK_MMU   = 3'd3,
        TK_BRK   = 3'd4
    } trap_kind_e;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_MMU_PEND = 2'd1,
        ST_HALT     = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/trap_prio.sv
module trap_prio #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_slot
            assign grant[g]  = req[g] & ~seen[g];
            assign seen[g+1] = seen[g] | req[g];
        end
    endgenerate
endmodule

// File: rtl/trap_req_filter.sv
module trap_req_filter
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            irq_req,
    input  logic            hwexc_req,
    input  logic            mmu_req,
    input  logic            brk_req,
    input  logic [XLEN-1:0] cur_msr,
    input  logic            in_dslot,
    input  logic            after_imm,
    output logic            any_grant,
    output trap_kind_e      kind
);
    logic            irq_ok;
    logic [NREQ-1:0] elig;
    logic [NREQ-1:0] grant;

    always_comb begin
        irq_ok = irq_req && cur_msr[MSR_IE] && !cur_msr[MSR_EIP]
                 && !cur_msr[MSR_BIP] && !in_dslot && !after_imm;
        elig           = '0;
        elig[SLOT_BRK] = brk_req;
        elig[SLOT_MMU] = mmu_req;
        elig[SLOT_HWX] = hwexc_req;
        elig[SLOT_IRQ] = irq_ok;
    end

    trap_prio #(.N(NREQ)) prio_i (
        .req   (elig),
        .grant (grant)
    );

    always_comb begin
        any_grant = |grant;
        if (grant[SLOT_BRK])      kind = TK_BRK;
        else if (grant[SLOT_MMU]) kind = TK_MMU;
        else if (grant[SLOT_HWX]) kind = TK_HWEXC;
        else if (grant[SLOT_IRQ]) kind = TK_IRQ;
        else                      kind = TK_NONE;
    end
endmodule

// File: rtl/trap_frame.sv
module trap_frame
    import trap_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              RIDX_W   = 5,
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input  trap_kind_e        kind,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   cur_btarget,
    input  logic              in_dslot,
    input  logic              after_imm,
    input  logic              branch_had_imm,
    input  logic [XLEN-1:0]   cur_msr,
    input  logic [XLEN-1:0]   cur_esr,
    input  logic [1:0]        mmu_cause,
    input  logic              mmu_store,
    input  logic [XLEN-1:0]   mmu_addr,
    output logic [XLEN-1:0]   new_pc,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_idx,
    output logic [XLEN-1:0]   rf_data,
    output logic              msr_we,
    output logic [XLEN-1:0]   msr_next,
    output logic              esr_we,
    output logic [XLEN-1:0]   esr_next,
    output logic              ear_we,
    output logic [XLEN-1:0]   ear_next,
    output logic              btr_we,
    output logic [XLEN-1:0]   btr_next,
    output logic              flags_clr
);
    localparam logic [XLEN-1:0] WORD    = XLEN'(XLEN / 8);
    localparam logic [XLEN-1:0] VEC_IRQ = VEC_BASE + XLEN'(VOFS_IRQ);
    localparam logic [XLEN-1:0] VEC_BRK = VEC_BASE + XLEN'(VOFS_BRK);
    localparam logic [XLEN-1:0] VEC_EXC = VEC_BASE + XLEN'(VOFS_EXC);

    logic            is_exc;
    logic [XLEN-1:0] mode_msr;
    logic [XLEN-1:0] mmu_ret;
    logic [XLEN-1:0] mmu_esr;

    // privileged, untranslated status with saved copies
    always_comb begin
        mode_msr                     = cur_msr;
        mode_msr[MSR_VM+SHADOW_OFS]  = cur_msr[MSR_VM];
        mode_msr[MSR_UM+SHADOW_OFS]  = cur_msr[MSR_UM];
        mode_msr[MSR_VM]             = 1'b0;
        mode_msr[MSR_UM]             = 1'b0;
    end

    // rewind so that a faulting slot re-runs its branch
    always_comb begin
        if (in_dslot)       mmu_ret = branch_had_imm ? cur_pc - (WORD << 1) : cur_pc - WORD;
        else if (after_imm) mmu_ret = cur_pc - WORD;
        else                mmu_ret = cur_pc;
    end

    always_comb begin
        mmu_esr             = '0;
        mmu_esr[4:0]        = 5'(ESR_MMU_BASE) | {3'b000, mmu_cause};
        mmu_esr[ESR_ST_BIT] = mmu_store;
    end

    always_comb begin
        is_exc    = (kind == TK_HWEXC) || (kind == TK_MMU);
        new_pc    = '0;
        rf_we     = 1'b0;
        rf_idx    = '0;
        rf_data   = '0;
        msr_we    = 1'b0;
        msr_next  = mode_msr;
        esr_we    = 1'b0;
        esr_next  = cur_esr;
        ear_we    = 1'b0;
        ear_next  = mmu_addr;
        btr_we    = 1'b0;
        btr_next  = cur_btarget;
        flags_clr = 1'b0;
        unique case (kind)
            TK_IRQ: begin
                new_pc  = VEC_IRQ;
                rf_we   = 1'b1;
                rf_idx  = RIDX_W'(RET_IRQ);
                rf_data = cur_pc;
                msr_we  = 1'b1;
            end
            TK_BRK: begin
                new_pc            = VEC_BRK;
                rf_we             = 1'b1;
                rf_idx            = RIDX_W'(RET_BRK);
                rf_data           = cur_pc;
                msr_we            = 1'b1;
                msr_next[MSR_BIP] = 1'b1;
            end
            TK_HWEXC: begin
                new_pc   = VEC_EXC;
                rf_we    = 1'b1;
                rf_idx   = RIDX_W'(RET_EXC);
                rf_data  = cur_pc + WORD;
                esr_next = cur_esr;
            end
            TK_MMU: begin
                new_pc   = VEC_EXC;
                rf_we    = 1'b1;
                rf_idx   = RIDX_W'(RET_EXC);
                rf_data  = mmu_ret;
                esr_next = mmu_esr;
                ear_we   = 1'b1;
            end
            default: begin
            end
        endcase
        if (is_exc) begin
            msr_we               = 1'b1;
            msr_next[MSR_EIP]    = 1'b1;
            esr_we               = 1'b1;
            esr_next[ESR_DS_BIT] = in_dslot;
            btr_we               = in_dslot;
            flags_clr            = 1'b1;
        end
    end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              RIDX_W   = 5,
    parameter logic [XLEN-1:0] VEC_BASE = XLEN'(32'h1000_0000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic              hwexc_req,
    input  logic              mmu_req,
    input  logic [1:0]        mmu_cause,
    input  logic              mmu_store,
    input  logic [XLEN-1:0]   mmu_addr,
    input  logic              brk_req,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   cur_btarget,
    input  logic              in_dslot,
    input  logic              after_imm,
    input  logic              branch_had_imm,
    input  logic [XLEN-1:0]   cur_msr,
    input  logic [XLEN-1:0]   cur_esr,
    output logic              entry_taken,
    output logic [2:0]        entry_kind,
    output logic [XLEN-1:0]   new_pc,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_idx,
    output logic [XLEN-1:0]   rf_data,
    output logic              msr_we,
    output logic [XLEN-1:0]   msr_next,
    output logic              esr_we,
    output logic [XLEN-1:0]   esr_next,
    output logic              ear_we,
    output logic [XLEN-1:0]   ear_next,
    output logic              btr_we,
    output logic [XLEN-1:0]   btr_next,
    output logic              flags_clr,
    output logic              fatal_err
);
    ctl_state_e state, state_nx;
    trap_kind_e req_kind;
    trap_kind_e eff_kind;
    logic       any_grant;
    logic       go;
    logic       recur;

    trap_req_filter #(.XLEN(XLEN)) filt_i (
        .irq_req   (irq_req),
        .hwexc_req (hwexc_req),
        .mmu_req   (mmu_req),
        .brk_req   (brk_req),
        .cur_msr   (cur_msr),
        .in_dslot  (in_dslot),
        .after_imm (after_imm),
        .any_grant (any_grant),
        .kind      (req_kind)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // entry decision per state
    always_comb begin
        go        = 1'b0;
        recur     = 1'b0;
        fatal_err = 1'b0;
        unique case (state)
            ST_RUN: begin
                go = rst_n && any_grant;
            end
            ST_MMU_PEND: begin
                recur = mmu_req;
                go    = rst_n && any_grant && !mmu_req;
            end
            ST_HALT: begin
                fatal_err = 1'b1;
            end
            default: begin
            end
        endcase
        eff_kind    = go ? req_kind : TK_NONE;
        entry_taken = go;
        entry_kind  = eff_kind;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (go && req_kind == TK_MMU) state_nx = ST_MMU_PEND;
            end
            ST_MMU_PEND: begin
                if (recur)                  state_nx = ST_HALT;
                else if (!cur_msr[MSR_EIP]) state_nx = ST_RUN;
            end
            ST_HALT: begin
                state_nx = ST_HALT;
            end
            default: state_nx = ST_RUN;
        endcase
    end

    trap_frame #(
        .XLEN     (XLEN),
        .RIDX_W   (RIDX_W),
        .VEC_BASE (VEC_BASE)
    ) frame_i (
        .kind           (eff_kind),
        .cur_pc         (cur_pc),
        .cur_btarget    (cur_btarget),
        .in_dslot       (in_dslot),
        .after_imm      (after_imm),
        .branch_had_imm (branch_had_imm),
        .cur_msr        (cur_msr),
        .cur_esr        (cur_esr),
        .mmu_cause      (mmu_cause),
        .mmu_store      (mmu_store),
        .mmu_addr       (mmu_addr),
        .new_pc         (new_pc),
        .rf_we          (rf_we),
        .rf_idx         (rf_idx),
        .rf_data        (rf_data),
        .msr_we         (msr_we),
        .msr_next       (msr_next),
        .esr_we         (esr_we),
        .esr_next       (esr_next),
        .ear_we         (ear_we),
        .ear_next       (ear_next),
        .btr_we         (btr_we),
        .btr_next       (btr_next),
        .flags_clr      (flags_clr)
    );
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
    import trap_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              RIDX_W   = 5,
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_req,
    input logic              mmu_req,
    input logic              brk_req,
    input logic [XLEN-1:0]   cur_pc,
    input logic [XLEN-1:0]   cur_btarget,
    input logic              in_dslot,
    input logic              after_imm,
    input logic [XLEN-1:0]   cur_msr,
    input logic [XLEN-1:0]   mmu_addr,
    input logic              entry_taken,
    input logic [2:0]        entry_kind,
    input logic [XLEN-1:0]   new_pc,
    input logic              rf_we,
    input logic [RIDX_W-1:0] rf_idx,
    input logic [XLEN-1:0]   rf_data,
    input logic              msr_we,
    input logic [XLEN-1:0]   msr_next,
    input logic              esr_we,
    input logic              ear_we,
    input logic [XLEN-1:0]   ear_next,
    input logic              btr_we,
    input logic [XLEN-1:0]   btr_next,
    input logic              flags_clr,
    input logic              fatal_err
);
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_taken && entry_kind == 3'd1) |-> (cur_msr[MSR_IE] && !cur_msr[MSR_EIP] && !cur_msr[MSR_BIP] && !in_dslot && !after_imm)); // R1
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !entry_taken |-> (!rf_we && !msr_we && !esr_we && !ear_we && !btr_we)); // R2
    AST_BRK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && !mmu_req && !fatal_err) |-> (entry_taken && entry_kind == 3'd4)); // R2
    AST_EXC_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_taken && (entry_kind == 3'd2 || entry_kind == 3'd3)) |-> (new_pc == VEC_BASE + XLEN'(VOFS_EXC))); // R3
    AST_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        msr_we |-> (!msr_next[MSR_VM] && !msr_next[MSR_UM] && msr_next[MSR_VM+1] == cur_msr[MSR_VM])); // R4
    AST_IRQ_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_taken && entry_kind == 3'd1) |-> (rf_idx == RIDX_W'(RET_IRQ) && rf_data == cur_pc)); // R5
    AST_BTR_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        btr_we |-> (in_dslot && btr_next == cur_btarget)); // R7
    AST_EAR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ear_we |-> (entry_kind == 3'd3 && ear_next == mmu_addr)); // R9
    AST_FLAGS_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        flags_clr |-> (entry_taken && (entry_kind == 3'd2 || entry_kind == 3'd3))); // R10
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_err |=> fatal_err); // R11
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_err |-> !entry_taken); // R11
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!entry_taken && !fatal_err)); // R12
endmodule

bind trap_entry_ctrl trap_entry_chk #(
    .XLEN     (XLEN),
    .RIDX_W   (RIDX_W),
    .VEC_BASE (VEC_BASE)
) chk_i (.*);

// File: tb/trap_entry_ctrl_tb_top.sv
module trap_entry_ctrl_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] VB    = 32'h1000_0000;
    localparam logic [31:0] PC    = 32'h0000_2000;
    localparam logic [31:0] BT    = 32'h0000_3000;
    localparam logic [31:0] ESR0  = 32'h0000_1005;
    localparam logic [31:0] FADDR = 32'hDEAD_BEE0;
    localparam logic [31:0] M_ON  = 32'h0000_2802; // IE, UM, VM
    localparam logic [31:0] M_EIP = 32'h0000_0200;
    localparam logic [31:0] M_BIP = 32'h0000_0008;

    typedef struct packed {
        logic        irq, hwx, mmu, brk;
        logic [1:0]  cause;
        logic        st, ds, im, bim;
        logic [31:0] msr;
        logic [2:0]  kind;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,M_ON,3'd1},
        '{1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,32'h0000_2800,3'd0},
        '{1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,M_ON|M_EIP,3'd0},
        '{1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,M_ON|M_BIP,3'd0},
        '{1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,1'b1,1'b0,1'b0,M_ON,3'd0},
        '{1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b1,1'b0,M_ON,3'd0},
        '{1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,M_ON,3'd2},
        '{1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,1'b1,1'b0,1'b0,M_ON,3'd2},
        '{1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b1,1'b0,M_ON,3'd2},
        '{1'b0,1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,M_ON,3'd3},
        '{1'b0,1'b0,1'b1,1'b0,2'd1,1'b1,1'b0,1'b0,1'b0,M_ON,3'd3},
        '{1'b0,1'b0,1'b1,1'b0,2'd2,1'b0,1'b1,1'b0,1'b0,M_ON,3'd3},
        '{1'b0,1'b0,1'b1,1'b0,2'd3,1'b0,1'b1,1'b0,1'b1,M_ON,3'd3},
        '{1'b0,1'b0,1'b1,1'b0,2'd2,1'b1,1'b0,1'b1,1'b0,M_ON,3'd3},
        '{1'b0,1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0,M_ON,3'd4},
        '{1'b0,1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0,32'h0000_4002,3'd4},
        '{1'b1,1'b1,1'b1,1'b1,2'd1,1'b1,1'b0,1'b0,1'b0,M_ON,3'd4},
        '{1'b1,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,M_ON,3'd3},
        '{1'b1,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,M_ON,3'd2},
        '{1'b1,1'b1,1'b0,1'b0,2'd0,1'b0,1'b1,1'b0,1'b0,M_ON,3'd2},
        '{1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,M_ON,3'd0},
        '{1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,32'h0000_4002,3'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req, hwexc_req, mmu_req, brk_req, mmu_store;
    logic [1:0]  mmu_cause;
    logic [31:0] mmu_addr, cur_pc, cur_btarget, cur_msr, cur_esr;
    logic        in_dslot, after_imm, branch_had_imm;
    logic        entry_taken, rf_we, msr_we, esr_we, ear_we, btr_we, flags_clr, fatal_err;
    logic [2:0]  entry_kind;
    logic [4:0]  rf_idx;
    logic [31:0] new_pc, rf_data, msr_next, esr_next, ear_next, btr_next;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    trap_entry_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .irq_req(irq_req), .hwexc_req(hwexc_req), .mmu_req(mmu_req),
        .mmu_cause(mmu_cause), .mmu_store(mmu_store), .mmu_addr(mmu_addr),
        .brk_req(brk_req), .cur_pc(cur_pc), .cur_btarget(cur_btarget),
        .in_dslot(in_dslot), .after_imm(after_imm), .branch_had_imm(branch_had_imm),
        .cur_msr(cur_msr), .cur_esr(cur_esr),
        .entry_taken(entry_taken), .entry_kind(entry_kind), .new_pc(new_pc),
        .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data),
        .msr_we(msr_we), .msr_next(msr_next), .esr_we(esr_we), .esr_next(esr_next),
        .ear_we(ear_we), .ear_next(ear_next), .btr_we(btr_we), .btr_next(btr_next),
        .flags_clr(flags_clr), .fatal_err(fatal_err)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(vec_t v);
        irq_req = v.irq; hwexc_req = v.hwx; mmu_req = v.mmu; brk_req = v.brk;
        mmu_cause = v.cause; mmu_store = v.st; in_dslot = v.ds;
        after_imm = v.im; branch_had_imm = v.bim; cur_msr = v.msr;
        cur_pc = PC; cur_btarget = BT; cur_esr = ESR0; mmu_addr = FADDR;
    endtask

    function automatic vec_t idle_vec();
        vec_t v;
        v = '0;
        return v;
    endfunction

    // expected register values derived from the requirements
    task automatic check_entry(vec_t v);
        bit          exc;
        logic [31:0] e_pc, e_ret, e_msr, e_esr;
        logic [4:0]  e_idx;
        exc = (v.kind == 3'd2) || (v.kind == 3'd3);
        chk("R2", "entry_taken", {31'b0, entry_taken}, {31'b0, v.kind != 3'd0});
        chk((v.irq && !v.hwx && !v.mmu && !v.brk) ? "R1" : "R2", "entry_kind",
            {29'b0, entry_kind}, {29'b0, v.kind});
        if (v.kind == 3'd0) begin
            chk("R2", "rf_we idle", {31'b0, rf_we}, 32'd0);
            chk("R2", "msr_we idle", {31'b0, msr_we}, 32'd0);
            chk("R10", "flags_clr idle", {31'b0, flags_clr}, 32'd0);
            return;
        end
        case (v.kind)
            3'd1: begin e_pc = VB + 32'h10; e_idx = 5'd14; e_ret = PC; end
            3'd4: begin e_pc = VB + 32'h18; e_idx = 5'd16; e_ret = PC; end
            3'd2: begin e_pc = VB + 32'h20; e_idx = 5'd17; e_ret = PC + 32'd4; end
            default: begin
                e_pc = VB + 32'h20; e_idx = 5'd17;
                if (v.ds)      e_ret = v.bim ? PC - 32'd8 : PC - 32'd4;
                else if (v.im) e_ret = PC - 32'd4;
                else           e_ret = PC;
            end
        endcase
        e_msr = v.msr;
        e_msr[14] = v.msr[13];
        e_msr[12] = v.msr[11];
        e_msr[13] = 1'b0;
        e_msr[11] = 1'b0;
        if (exc) e_msr[9] = 1'b1;
        if (v.kind == 3'd4) e_msr[3] = 1'b1;
        if (v.kind == 3'd3) e_esr = 32'd16 + {30'b0, v.cause} + ({31'b0, v.st} << 10);
        else                e_esr = ESR0 & ~32'h0000_1000;
        if (v.ds) e_esr[12] = 1'b1;
        chk("R3", "new_pc", new_pc, e_pc);
        chk("R5", "rf_we", {31'b0, rf_we}, 32'd1);
        chk("R5", "rf_idx", {27'b0, rf_idx}, {27'b0, e_idx});
        chk((v.kind == 3'd3) ? "R6" : "R5", "rf_data", rf_data, e_ret);
        chk("R4", "msr_we", {31'b0, msr_we}, 32'd1);
        chk(exc || v.kind == 3'd4 ? "R8" : "R4", "msr_next", msr_next, e_msr);
        chk("R9", "esr_we", {31'b0, esr_we}, {31'b0, exc});
        if (exc) chk(v.kind == 3'd3 ? "R9" : "R7", "esr_next", esr_next, e_esr);
        chk("R9", "ear_we", {31'b0, ear_we}, {31'b0, v.kind == 3'd3});
        if (v.kind == 3'd3) chk("R9", "ear_next", ear_next, FADDR);
        chk("R7", "btr_we", {31'b0, btr_we}, {31'b0, exc && v.ds});
        if (exc && v.ds) chk("R7", "btr_next", btr_next, BT);
        chk("R10", "flags_clr", {31'b0, flags_clr}, {31'b0, exc});
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        vec_t v;
        // R12: requests during reset take no entry
        v = VECS[0];
        v.brk = 1'b1;
        drive(v);
        #3;
        chk("R12", "entry_taken in reset", {31'b0, entry_taken}, 32'd0);
        chk("R12", "fatal_err in reset", {31'b0, fatal_err}, 32'd0);
        chk("R12", "rf_we in reset", {31'b0, rf_we}, 32'd0);
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        drive(idle_vec());
        step();

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check_entry(VECS[i]);
            step();
            drive(idle_vec());
            @(negedge clk);
            chk("R2", "taken on idle", {31'b0, entry_taken}, 32'd0);
            step();
        end

        // R11: pending window, exit and recursive fault
        v = VECS[9];
        drive(v);
        @(negedge clk);
        chk("R11", "first fault taken", {29'b0, entry_kind}, 32'd3);
        step();
        v = VECS[6];
        v.msr = M_ON | M_EIP;
        drive(v);
        @(negedge clk);
        chk("R11", "hw exception while pending", {29'b0, entry_kind}, 32'd2);
        step();
        drive(idle_vec());
        step();
        v = VECS[9];
        v.msr = M_ON | M_EIP;
        drive(v);
        @(negedge clk);
        chk("R11", "fault after pending ended", {31'b0, entry_taken}, 32'd1);
        step();
        v.brk = 1'b1;
        drive(v);
        @(negedge clk);
        chk("R11", "recursive fault entry", {31'b0, entry_taken}, 32'd0);
        chk("R11", "fatal same cycle", {31'b0, fatal_err}, 32'd0);
        step();
        v = VECS[14];
        v.irq = 1'b1;
        drive(v);
        @(negedge clk);
        chk("R11", "fatal raised", {31'b0, fatal_err}, 32'd1);
        chk("R11", "break blocked in halt", {31'b0, entry_taken}, 32'd0);
        step();
        @(negedge clk);
        chk("R11", "fatal held", {31'b0, fatal_err}, 32'd1);
        rst_n = 1'b0;
        #1;
        chk("R12", "fatal cleared by reset", {31'b0, fatal_err}, 32'd0);
        step();
        rst_n = 1'b1;
        drive(VECS[14]);
        @(negedge clk);
        chk("R12", "entries resume after reset", {29'b0, entry_kind}, 32'd4);
        step();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule